// File: doc/BRIEF.md
# Burst NOR Wait-State Sequencer

This block runs the bus cycles for one external memory bank that holds a NOR flash or a cellular RAM device. A single host port hands it a request: read or write, plus a beat count. The block then drives the device strobes for that access. A control word sets how accesses behave. It enables the bank, allows or blocks writes, and chooses synchronous burst or asynchronous transfer, with a separate choice for reads and for writes. It also sets how the device's wait line is read: enable, polarity and alignment. Finally it selects the timing set and holds two initial-latency values.

A synchronous access has three parts. First comes one address cycle. Next come the programmed latency cycles. Last is a data phase, in which the wait line can stretch beats. The line can be read as a warning one cycle ahead of the stall, or during the stall itself. Asynchronous accesses skip both the latency and the wait line. An access to a disabled bank, or a write to a write-protected bank, ends at once with an error and drives no device strobe.

Top module: `nor_burst_seq`

## Requirements
- R1: The control word resets to bank enabled, writes allowed, wait sampling on, and everything else zero (value 0x0013). A write issued straight after reset therefore completes asynchronously without error, and `req_ready` is high with no strobe active.
- R2: With bank enable (bit 0) clear, an accepted access raises `rsp_done` and `rsp_err` in the cycle after acceptance. No device strobe is driven.
- R3: With write enable (bit 1) clear, an accepted write ends with the same error response, and reads still proceed.
- R4: Read burst (bit 2) selects synchronous reads (`dev_sync` high). When it is clear, a read is one address cycle followed by one beat per cycle, and both latency and wait are ignored.
- R5: Write burst (bit 3) selects synchronous writes in the same way. When it is clear, writes are asynchronous.
- R6: A synchronous access drives `dev_adv` for exactly one cycle. It then holds L cycles with no beat, where L is the selected 4-bit latency, before the data phase starts.
- R7: With wait enable (bit 4) clear, `dev_wait` has no effect: a beat occurs in every data-phase cycle.
- R8: With wait alignment (bit 6) set, the beat is withheld in any data-phase cycle in which the wait line is active.
- R9: With wait alignment clear, the beat is withheld in the data-phase cycle that follows a data-phase cycle in which the wait line was active. The first data cycle is never withheld.
- R10: The wait line is active when `dev_wait` XOR wait polarity (bit 5) is 1.
- R11: A synchronous write uses the write latency (bits 15:12) when extended timing (bit 7) is set. Otherwise it uses the read latency (bits 11:8), which reads always use.
- R12: An access that is not rejected delivers exactly `req_len`+1 beats. `rsp_done` then rises for one cycle, with `rsp_err` low, in the cycle after the last beat, and the block returns to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load `cfg_word` into the control word |
| cfg_word | input | 16 | New control word |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Beats minus one |
| req_ready | output | 1 | Sequencer idle and accepting |
| dev_wait | input | 1 | Device wait line |
| dev_sel | output | 1 | Device select |
| dev_adv | output | 1 | Address phase strobe |
| dev_rd | output | 1 | Read strobe |
| dev_wr | output | 1 | Write strobe |
| dev_sync | output | 1 | Access is synchronous burst |
| beat | output | 1 | A data beat completes this cycle |
| rsp_done | output | 1 | Access finished |
| rsp_err | output | 1 | Access rejected (bus error) |

## Verification
The bench builds the block with `LEN_W` = 3, so bursts run from one to eight beats. It uses the full 4-bit latency range, from zero (data phase straight after the address cycle) up to fifteen. With these values every latency value is reached, along with short and long bursts. Long bursts let many wait patterns occur in both alignments, including back-to-back stalls and a wait asserted on the final beat.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int LAT_W = 4;
    localparam int CFG_W = 8 + 2 * LAT_W;

    typedef struct packed {
        logic [LAT_W-1:0] wr_lat;
        logic [LAT_W-1:0] rd_lat;
        logic             ext_tim;
        logic             wait_align;
        logic             wait_pol;
        logic             wait_en;
        logic             wr_burst;
        logic             rd_burst;
        logic             wr_en;
        logic             bank_en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        wr_lat: '0, rd_lat: '0, ext_tim: 1'b0, wait_align: 1'b0,
        wait_pol: 1'b0, wait_en: 1'b1, wr_burst: 1'b0, rd_burst: 1'b0,
        wr_en: 1'b1, bank_en: 1'b1
    };

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_LAT,
        S_DATA,
        S_RESP
    } seq_state_t;

    function automatic logic is_sync(input ctl_t c, input logic wr);
        return wr ? c.wr_burst : c.rd_burst;
    endfunction

    function automatic logic [LAT_W-1:0] pick_lat(input ctl_t c, input logic wr);
        if (!is_sync(c, wr))
            return '0;
        return (wr && c.ext_tim) ? c.wr_lat : c.rd_lat;
    endfunction

endpackage

// File: rtl/nor_ctl_reg.sv
module nor_ctl_reg
    import nor_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] word,
    output ctl_t             ctl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= CTL_RESET;
        else if (load)
            ctl <= ctl_t'(word);
    end
endmodule

// File: rtl/nor_lat_cnt.sv
module nor_lat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic         zero,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
    assign last = (cnt == W'(1));
endmodule

// File: rtl/nor_wait_unit.sv
module nor_wait_unit (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sample,
    input  logic en,
    input  logic align,
    input  logic pol,
    input  logic wait_in,
    output logic stall
);
    logic act;
    logic pend;

    assign act = en && (wait_in ^ pol);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pend <= 1'b0;
        else if (sample)
            pend <= act;
    end

    assign stall = align ? act : (en && pend);
endmodule

// File: rtl/nor_burst_seq.sv
module nor_burst_seq
    import nor_seq_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic             dev_wait,
    output logic             dev_sel,
    output logic             dev_adv,
    output logic             dev_rd,
    output logic             dev_wr,
    output logic             dev_sync,
    output logic             beat,
    output logic             rsp_done,
    output logic             rsp_err
);
    ctl_t             ctl;
    seq_state_t       state;
    logic             wr_q;
    logic             sync_q;
    logic             err_q;
    logic [LEN_W-1:0] left;
    logic             accept;
    logic             blocked;
    logic             lat_zero;
    logic             lat_last;
    logic             in_data;
    logic             stall;

    nor_ctl_reg u_ctl (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .word (cfg_word),
        .ctl  (ctl)
    );

    assign accept  = req_valid && (state == S_IDLE);
    assign blocked = !ctl.bank_en || (req_write && !ctl.wr_en);
    assign in_data = (state == S_DATA);

    nor_lat_cnt #(.W(LAT_W)) u_lat (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .val  (pick_lat(ctl, req_write)),
        .dec  (state == S_LAT),
        .zero (lat_zero),
        .last (lat_last)
    );

    nor_wait_unit u_wait (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .sample  (in_data),
        .en      (in_data && sync_q && ctl.wait_en),
        .align   (ctl.wait_align),
        .pol     (ctl.wait_pol),
        .wait_in (dev_wait),
        .stall   (stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            wr_q   <= 1'b0;
            sync_q <= 1'b0;
            err_q  <= 1'b0;
            left   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        wr_q   <= req_write;
                        sync_q <= is_sync(ctl, req_write);
                        err_q  <= blocked;
                        left   <= req_len;
                        state  <= blocked ? S_RESP : S_ADDR;
                    end
                end
                S_ADDR: state <= lat_zero ? S_DATA : S_LAT;
                S_LAT: begin
                    if (lat_last)
                        state <= S_DATA;
                end
                S_DATA: begin
                    if (!stall) begin
                        if (left == '0)
                            state <= S_RESP;
                        else
                            left <= left - 1'b1;
                    end
                end
                S_RESP: begin
                    state <= S_IDLE;
                    err_q <= 1'b0;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign dev_sel   = (state == S_ADDR) || (state == S_LAT) || in_data;
    assign dev_adv   = (state == S_ADDR);
    assign dev_rd    = dev_sel && !wr_q;
    assign dev_wr    = dev_sel && wr_q;
    assign dev_sync  = dev_sel && sync_q;
    assign beat      = in_data && !stall;
    assign rsp_done  = (state == S_RESP);
    assign rsp_err   = rsp_done && err_q;
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk
    import nor_seq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_write,
    input logic req_ready,
    input logic dev_wait,
    input logic dev_sel,
    input logic dev_adv,
    input logic dev_sync,
    input logic beat,
    input logic rsp_done,
    input logic rsp_err,
    input ctl_t ctl
);
    // R2
    err_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> !dev_sel && !beat);

    // R2
    bank_off_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !ctl.bank_en) |=> (rsp_done && rsp_err));

    // R3
    wr_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && !ctl.wr_en) |=> (rsp_done && rsp_err));

    // R6
    adv_single_chk: assert property (@(posedge clk) disable iff (rst)
        dev_adv |=> !dev_adv && !rsp_done);

    // R6
    beat_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        beat |-> dev_sel && !dev_adv);

    // R8
    wait_during_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_sync && ctl.wait_en && ctl.wait_align && (dev_wait ^ ctl.wait_pol)) |-> !beat);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done && req_ready);
endmodule

bind nor_burst_seq nor_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .dev_wait  (dev_wait),
    .dev_sel   (dev_sel),
    .dev_adv   (dev_adv),
    .dev_sync  (dev_sync),
    .beat      (beat),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .ctl       (ctl)
);

// File: tb/sim_nor_burst_seq.sv
module sim_nor_burst_seq;
    localparam int LEN_W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_load = 1'b0;
    logic [15:0]  cfg_word = '0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic         req_ready;
    logic         dev_wait = 1'b0;
    logic         dev_sel, dev_adv, dev_rd, dev_wr, dev_sync, beat, rsp_done, rsp_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bench copy of the control word
    bit m_bank = 1, m_wren = 1, m_rb = 0, m_wb = 0, m_wen = 1, m_pol = 0, m_al = 0, m_ext = 0;
    int m_rl = 0, m_wl = 0;

    nor_burst_seq #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write), .req_len(req_len),
        .req_ready(req_ready), .dev_wait(dev_wait), .dev_sel(dev_sel),
        .dev_adv(dev_adv), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_sync(dev_sync),
        .beat(beat), .rsp_done(rsp_done), .rsp_err(rsp_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog R12: actual %0d cycles, expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_word();
        return {4'(m_wl), 4'(m_rl), m_ext, m_al, m_pol, m_wen, m_wb, m_rb, m_wren, m_bank};
    endfunction

    task automatic load_cfg();
        @(negedge clk);
        cfg_word = mk_word();
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run_tx(input bit wr, input int len, input int wprob, input string tag);
        bit exp_err, sync, prev, w, act, stall, fin;
        bit strobe_ok, beat_ok, done_ok;
        int lat, n, got, c;
        exp_err = !m_bank || (wr && !m_wren);
        sync = wr ? m_wb : m_rb;
        lat = !sync ? 0 : ((wr && m_ext) ? m_wl : m_rl);
        n = len + 1;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_len = LEN_W'(len);
        @(posedge clk);
        c = 0; got = 0; prev = 0; fin = 0;
        strobe_ok = 1; beat_ok = 1; done_ok = 0;
        while (!fin && c < 400) begin
            @(negedge clk);
            req_valid = 1'b0;
            c++;
            w = ($urandom % 100) < wprob;
            dev_wait = w ^ m_pol;
            #1;
            if (exp_err) begin
                done_ok = rsp_done && rsp_err && !dev_sel && !dev_rd && !dev_wr && !beat;
                fin = 1;
            end else if (c == 1) begin
                strobe_ok &= dev_sel && dev_adv && !beat && (dev_sync == sync)
                             && (dev_wr == wr) && (dev_rd == !wr);
            end else if (c <= lat + 1) begin
                strobe_ok &= dev_sel && !dev_adv && !beat && !rsp_done;
            end else if (got < n) begin
                act = sync && m_wen && w;
                stall = m_al ? act : prev;
                prev = act;
                if (beat != !stall) begin
                    beat_ok = 0;
                    $display("  cycle %0d beat %0d expected %0d", c, beat, !stall);
                end
                if (beat) got++;
            end else begin
                done_ok = rsp_done && !rsp_err && !dev_sel && !beat;
                fin = 1;
            end
        end
        if (exp_err) begin
            check(done_ok && c == 1, tag, c, 1);
        end else begin
            check(strobe_ok, {tag, " R6 addr/latency phase"}, strobe_ok, 1);
            check(beat_ok && got == n, {tag, " beats"}, got, n);
            check(done_ok, "R12 done after last beat", c, lat + 1 + n + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !dev_sel && !rsp_done, "R1 idle after reset", dev_sel, 0);
        run_tx(1, 2, 50, "R1 write after reset");
        run_tx(0, 0, 50, "R4 async read after reset");

        // R2 disabled bank
        m_bank = 0; load_cfg();
        run_tx(0, 3, 0, "R2 read disabled bank");
        run_tx(1, 3, 0, "R2 write disabled bank");

        // R3 write protect
        m_bank = 1; m_wren = 0; load_cfg();
        run_tx(1, 1, 0, "R3 write protected");
        run_tx(0, 4, 30, "R3 read on protected bank");

        // R7 wait disabled, latency 3, sync read
        m_wren = 1; m_rb = 1; m_rl = 3; m_wen = 0; load_cfg();
        run_tx(0, 7, 60, "R7 wait ignored");

        // R8 during alignment
        m_wen = 1; m_al = 1; load_cfg();
        run_tx(0, 7, 30, "R8 wait during");
        // R9 ahead alignment
        m_al = 0; load_cfg();
        run_tx(0, 7, 30, "R9 wait ahead");
        // R10 polarity
        m_pol = 1; load_cfg();
        run_tx(0, 5, 30, "R10 inverted wait");
        m_al = 1; load_cfg();
        run_tx(0, 5, 30, "R10 inverted wait during");

        // R6 zero and max latency
        m_pol = 0; m_rl = 0; load_cfg();
        run_tx(0, 2, 20, "R6 latency zero");
        m_rl = 15; load_cfg();
        run_tx(0, 2, 20, "R6 latency fifteen");

        // R5 / R11 write timing
        m_rl = 2; m_wl = 5; m_wb = 1; m_ext = 1; load_cfg();
        run_tx(1, 3, 25, "R11 write uses write latency");
        m_ext = 0; load_cfg();
        run_tx(1, 3, 25, "R11 write uses read latency");
        m_wb = 0; load_cfg();
        run_tx(1, 3, 60, "R5 async write while reads burst");
        run_tx(0, 3, 25, "R4 sync read");

        // constrained random
        for (int i = 0; i < 60; i++) begin
            m_bank = ($urandom % 8) != 0;
            m_wren = ($urandom % 4) != 0;
            m_rb = $urandom % 2; m_wb = $urandom % 2;
            m_wen = $urandom % 2; m_pol = $urandom % 2;
            m_al = $urandom % 2; m_ext = $urandom % 2;
            m_rl = $urandom % 16; m_wl = $urandom % 16;
            load_cfg();
            run_tx($urandom % 2, $urandom % 8, $urandom % 41, "R12 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule